// File: doc/BRIEF.md
# Character I/O and Interrupt-Enable Unit

This unit carries out the input/output group of an accumulator machine's instruction set. It connects the low byte of a 16-bit accumulator to an 8-bit receive character bus and an 8-bit transmit character bus. It holds a receive-ready flag, a transmit-ready flag and an interrupt-enable bit. The CPU raises an execute strobe together with an instruction word. In the same cycle the unit returns the updated accumulator value with a write enable, and a skip request. State changes take effect at the following clock edge.

External logic sets the flags through single-cycle strobes. A receiver pulses `rx_strobe` when a new character is present on `rx_char`. A transmitter pulses `tx_done` when it can accept the next character. The unit raises an interrupt request whenever interrupts are enabled and at least one flag is set. The CPU takes care of vectoring. The `IRQ_REG` parameter selects whether that request is combinational or registered.

Top module: `char_io_unit`

## Requirements
- R1: Reset gives the following state: rx_flag=0, tx_flag=1, int_en=0, tx_valid=0, tx_char=0 and irq=0.
- R2: Load-character (word 0xF800 with exec_en=1) has the following effect in the same cycle: acc_we=1, and acc_out is acc_in with bits 7-0 replaced by rx_char (bits 15-8 kept). rx_flag clears at the next edge. For any other input, acc_we=0 and acc_out equals acc_in.
- R3: Send-character (word 0xF400 with exec_en=1) has the following effect after the next edge: tx_char holds the previous acc_in bits 7-0, tx_valid is high for exactly one cycle, and tx_flag is 0.
- R4: Skip-if-received (word 0xF200) raises skip_req in the same cycle only when rx_flag=1. Skip-if-sendable (word 0xF100) raises it only when tx_flag=1.
- R5: Word 0xF080 sets int_en at the next edge. Word 0xF040 clears it at the next edge.
- R6: rx_strobe sets rx_flag and tx_done sets tx_flag at the next edge. When a strobe arrives in the same cycle as an instruction that clears the same flag, the set takes priority.
- R7: irq = int_en AND (rx_flag OR tx_flag). With IRQ_REG=0 this follows the registered state with no extra delay.
- R8: A word other than the six codes above, or any word with exec_en=0, is ignored. acc_we and skip_req stay 0, tx_valid stays 0, and rx_flag, tx_flag and int_en keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exec_en | input | 1 | Execute strobe for the presented instruction |
| instr | input | 16 | Instruction word |
| acc_in | input | ACC_W | Current accumulator |
| rx_char | input | CHAR_W | Receive character bus |
| rx_strobe | input | 1 | New receive character present; sets rx_flag |
| tx_done | input | 1 | Transmitter ready for another character; sets tx_flag |
| acc_out | output | ACC_W | Accumulator value to write back |
| acc_we | output | 1 | Accumulator write enable |
| skip_req | output | 1 | Request to skip the next instruction |
| tx_char | output | CHAR_W | Transmit character register |
| tx_valid | output | 1 | One-cycle pulse marking a new tx_char |
| rx_flag | output | 1 | Receive-ready flag |
| tx_flag | output | 1 | Transmit-ready flag |
| int_en | output | 1 | Interrupt-enable bit |
| irq | output | 1 | Interrupt request |

## Verification
The outputs acc_out, acc_we and skip_req are due in the same cycle as the execute strobe. The bench drives inputs on a falling edge and samples these outputs 1 ns later, before the next rising edge. The flags, int_en, tx_char, tx_valid and irq (with IRQ_REG=0) are due one rising edge after the stimulus. The bench samples them 1 ns after the following falling edge, and checks that tx_valid has dropped one cycle after that. The bench checks each ignored word at the ports: acc_we and skip_req in the cycle it is applied, and the flags, int_en and tx_valid in the following cycle.

// File: rtl/char_io_pkg.sv
package char_io_pkg;
   localparam int unsigned IO_WORD_W = 16;

   localparam logic [IO_WORD_W-1:0] CODE_LDCH  = 16'hF800;
   localparam logic [IO_WORD_W-1:0] CODE_SNDCH = 16'hF400;
   localparam logic [IO_WORD_W-1:0] CODE_SKRX  = 16'hF200;
   localparam logic [IO_WORD_W-1:0] CODE_SKTX  = 16'hF100;
   localparam logic [IO_WORD_W-1:0] CODE_INTON = 16'hF080;
   localparam logic [IO_WORD_W-1:0] CODE_INTOF = 16'hF040;

   typedef enum logic [2:0] {
      OP_NONE  = 3'd0,
      OP_LDCH  = 3'd1,
      OP_SNDCH = 3'd2,
      OP_SKRX  = 3'd3,
      OP_SKTX  = 3'd4,
      OP_INTON = 3'd5,
      OP_INTOF = 3'd6
   } io_op_e;
endpackage

// File: rtl/cio_decode.sv
module cio_decode
   import char_io_pkg::*;
(
   input  logic                 exec_en,
   input  logic [IO_WORD_W-1:0] instr,
   output io_op_e               op
);
   always_comb begin
      op = OP_NONE;
      if (exec_en) begin
         case (instr)
            CODE_LDCH:  op = OP_LDCH;
            CODE_SNDCH: op = OP_SNDCH;
            CODE_SKRX:  op = OP_SKRX;
            CODE_SKTX:  op = OP_SKTX;
            CODE_INTON: op = OP_INTON;
            CODE_INTOF: op = OP_INTOF;
            default:    op = OP_NONE;
         endcase
      end
   end
endmodule

// File: rtl/cio_flags.sv
module cio_flags
   import char_io_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  io_op_e op,
   input  logic   rx_strobe,
   input  logic   tx_done,
   output logic   rx_flag,
   output logic   tx_flag,
   output logic   int_en
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rx_flag <= 1'b0;
      end else if (rx_strobe) begin
         rx_flag <= 1'b1;
      end else if (op == OP_LDCH) begin
         rx_flag <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tx_flag <= 1'b1;
      end else if (tx_done) begin
         tx_flag <= 1'b1;
      end else if (op == OP_SNDCH) begin
         tx_flag <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         int_en <= 1'b0;
      end else if (op == OP_INTON) begin
         int_en <= 1'b1;
      end else if (op == OP_INTOF) begin
         int_en <= 1'b0;
      end
   end
endmodule

// File: rtl/cio_tx.sv
module cio_tx
   import char_io_pkg::*;
#(
   parameter int unsigned CHAR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  io_op_e            op,
   input  logic [CHAR_W-1:0] char_in,
   output logic [CHAR_W-1:0] tx_char,
   output logic              tx_valid
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tx_char  <= '0;
         tx_valid <= 1'b0;
      end else begin
         tx_valid <= (op == OP_SNDCH);
         if (op == OP_SNDCH) begin
            tx_char <= char_in;
         end
      end
   end
endmodule

// File: rtl/char_io_unit.sv
module char_io_unit
   import char_io_pkg::*;
#(
   parameter int unsigned ACC_W   = 16,
   parameter int unsigned CHAR_W  = 8,
   parameter int unsigned IRQ_REG = 0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 exec_en,
   input  logic [IO_WORD_W-1:0] instr,
   input  logic [ACC_W-1:0]     acc_in,
   input  logic [CHAR_W-1:0]    rx_char,
   input  logic                 rx_strobe,
   input  logic                 tx_done,
   output logic [ACC_W-1:0]     acc_out,
   output logic                 acc_we,
   output logic                 skip_req,
   output logic [CHAR_W-1:0]    tx_char,
   output logic                 tx_valid,
   output logic                 rx_flag,
   output logic                 tx_flag,
   output logic                 int_en,
   output logic                 irq
);
   localparam bit FULL_WIDTH_CHAR = (CHAR_W == ACC_W);

   if (CHAR_W < 1) begin : g_bad_char_w
      $error("CHAR_W must be at least 1");
   end
   if (CHAR_W > ACC_W) begin : g_bad_acc_w
      $error("CHAR_W must not exceed ACC_W");
   end
   if (IRQ_REG > 1) begin : g_bad_irq_reg
      $error("IRQ_REG must be 0 or 1");
   end

   io_op_e            op;
   logic [ACC_W-1:0]  acc_loaded;
   logic              irq_next;

   cio_decode u_decode (
      .exec_en (exec_en),
      .instr   (instr),
      .op      (op)
   );

   cio_flags u_flags (
      .clk       (clk),
      .rst_n     (rst_n),
      .op        (op),
      .rx_strobe (rx_strobe),
      .tx_done   (tx_done),
      .rx_flag   (rx_flag),
      .tx_flag   (tx_flag),
      .int_en    (int_en)
   );

   cio_tx #(.CHAR_W(CHAR_W)) u_tx (
      .clk      (clk),
      .rst_n    (rst_n),
      .op       (op),
      .char_in  (acc_in[CHAR_W-1:0]),
      .tx_char  (tx_char),
      .tx_valid (tx_valid)
   );

   if (FULL_WIDTH_CHAR) begin : g_full_load
      assign acc_loaded = rx_char;
   end else begin : g_low_load
      assign acc_loaded = {acc_in[ACC_W-1:CHAR_W], rx_char};
   end

   always_comb begin
      acc_we   = (op == OP_LDCH);
      acc_out  = acc_we ? acc_loaded : acc_in;
      skip_req = ((op == OP_SKRX) && rx_flag) ||
                 ((op == OP_SKTX) && tx_flag);
   end

   assign irq_next = int_en & (rx_flag | tx_flag);

   if (IRQ_REG == 1) begin : g_irq_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            irq <= 1'b0;
         end else begin
            irq <= irq_next;
         end
      end
   end else begin : g_irq_comb
      assign irq = irq_next;
   end
endmodule

// File: rtl/char_io_chk.sv
module char_io_chk
   import char_io_pkg::*;
#(
   parameter int unsigned ACC_W   = 16,
   parameter int unsigned CHAR_W  = 8,
   parameter int unsigned IRQ_REG = 0
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 exec_en,
   input logic [IO_WORD_W-1:0] instr,
   input logic [ACC_W-1:0]     acc_in,
   input logic [CHAR_W-1:0]    rx_char,
   input logic                 rx_strobe,
   input logic                 tx_done,
   input logic [ACC_W-1:0]     acc_out,
   input logic                 acc_we,
   input logic                 skip_req,
   input logic [CHAR_W-1:0]    tx_char,
   input logic                 tx_valid,
   input logic                 rx_flag,
   input logic                 tx_flag,
   input logic                 int_en,
   input logic                 irq
);
   logic known_word;
   assign known_word = exec_en &&
      ((instr == CODE_LDCH) || (instr == CODE_SNDCH) || (instr == CODE_SKRX) ||
       (instr == CODE_SKTX) || (instr == CODE_INTON) || (instr == CODE_INTOF));

   AST_LOAD_LOW_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      acc_we |-> (acc_out[CHAR_W-1:0] == rx_char)); // R2
   AST_LOAD_CLEARS_RX: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_en && instr == CODE_LDCH && !rx_strobe) |=> !rx_flag); // R2
   AST_SEND_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_en && instr == CODE_SNDCH) |=> (tx_valid && tx_char == $past(acc_in[CHAR_W-1:0]))); // R3
   AST_SEND_CLEARS_TX: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_en && instr == CODE_SNDCH && !tx_done) |=> !tx_flag); // R3
   AST_SKIP_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      skip_req |-> (exec_en && (rx_flag || tx_flag))); // R4
   AST_INT_ON: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_en && instr == CODE_INTON) |=> int_en); // R5
   AST_INT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_en && instr == CODE_INTOF) |=> !int_en); // R5
   AST_RX_STROBE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      rx_strobe |=> rx_flag); // R6
   AST_TX_DONE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      tx_done |=> tx_flag); // R6
   AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      (!int_en && (IRQ_REG == 0 || !$past(int_en))) |-> !irq); // R7
   AST_IGNORED_NOW: assert property (@(posedge clk) disable iff (!rst_n)
      !known_word |-> (!acc_we && !skip_req)); // R8
   AST_IGNORED_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
      (!known_word && !rx_strobe && !tx_done) |=>
         ($stable(rx_flag) && $stable(tx_flag) && $stable(int_en) && !tx_valid)); // R8
endmodule

bind char_io_unit char_io_chk #(
   .ACC_W   (ACC_W),
   .CHAR_W  (CHAR_W),
   .IRQ_REG (IRQ_REG)
) u_chk (.*);

// File: tb/sim_char_io_unit.sv
module sim_char_io_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        exec_en = 1'b0;
   logic [15:0] instr = '0;
   logic [15:0] acc_in = '0;
   logic [7:0]  rx_char = '0;
   logic        rx_strobe = 1'b0;
   logic        tx_done = 1'b0;
   logic [15:0] acc_out;
   logic        acc_we;
   logic        skip_req;
   logic [7:0]  tx_char;
   logic        tx_valid;
   logic        rx_flag;
   logic        tx_flag;
   logic        int_en;
   logic        irq;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #2 clk = ~clk;

   char_io_unit u0 (
      .clk(clk), .rst_n(rst_n), .exec_en(exec_en), .instr(instr),
      .acc_in(acc_in), .rx_char(rx_char), .rx_strobe(rx_strobe),
      .tx_done(tx_done), .acc_out(acc_out), .acc_we(acc_we),
      .skip_req(skip_req), .tx_char(tx_char), .tx_valid(tx_valid),
      .rx_flag(rx_flag), .tx_flag(tx_flag), .int_en(int_en), .irq(irq)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic issue(input logic [15:0] w, input logic [15:0] a, input logic en);
      @(negedge clk);
      instr = w; acc_in = a; exec_en = en;
      #1;
   endtask

   task automatic settle();
      @(negedge clk);
      exec_en = 1'b0; rx_strobe = 1'b0; tx_done = 1'b0; instr = '0;
      #1;
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      #1;
      chk("R1", "rx_flag", rx_flag, 0);
      chk("R1", "tx_flag", tx_flag, 1);
      chk("R1", "int_en", int_en, 0);
      chk("R1", "tx_valid", tx_valid, 0);
      chk("R1", "tx_char", tx_char, 0);
      chk("R1", "irq", irq, 0);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
   endtask

   task automatic t_rx_and_skip();
      issue(16'hF200, 16'h0000, 1'b1);
      chk("R4", "skip with rx_flag=0", skip_req, 0);
      settle();
      @(negedge clk);
      rx_char = 8'hA5; rx_strobe = 1'b1;
      settle();
      chk("R6", "rx_flag after strobe", rx_flag, 1);
      chk("R7", "irq while disabled", irq, 0);
      issue(16'hF200, 16'h0000, 1'b1);
      chk("R4", "skip with rx_flag=1", skip_req, 1);
      settle();
      issue(16'hF100, 16'h0000, 1'b1);
      chk("R4", "skip with tx_flag=1", skip_req, 1);
      settle();
   endtask

   task automatic t_load();
      issue(16'hF800, 16'h12FF, 1'b1);
      chk("R2", "acc_we", acc_we, 1);
      chk("R2", "acc_out", acc_out, 16'h12A5);
      chk("R2", "no skip", skip_req, 0);
      settle();
      chk("R2", "rx_flag cleared", rx_flag, 0);
      chk("R2", "acc_we idle", acc_we, 0);
      issue(16'hF200, 16'h0000, 1'b1);
      chk("R4", "skip after load", skip_req, 0);
      settle();
   endtask

   task automatic t_send();
      issue(16'hF400, 16'hBE5A, 1'b1);
      chk("R2", "no write on send", acc_we, 0);
      chk("R2", "acc_out passes", acc_out, 16'hBE5A);
      settle();
      chk("R3", "tx_char", tx_char, 8'h5A);
      chk("R3", "tx_valid pulse", tx_valid, 1);
      chk("R3", "tx_flag cleared", tx_flag, 0);
      settle();
      chk("R3", "tx_valid one cycle", tx_valid, 0);
      chk("R3", "tx_char held", tx_char, 8'h5A);
      issue(16'hF100, 16'h0000, 1'b1);
      chk("R4", "skip with tx_flag=0", skip_req, 0);
      settle();
   endtask

   task automatic t_interrupts();
      issue(16'hF080, 16'h0000, 1'b1);
      settle();
      chk("R5", "int_en set", int_en, 1);
      chk("R7", "irq no flags", irq, 0);
      @(negedge clk);
      tx_done = 1'b1;
      settle();
      chk("R6", "tx_flag after done", tx_flag, 1);
      chk("R7", "irq with tx_flag", irq, 1);
      issue(16'hF040, 16'h0000, 1'b1);
      settle();
      chk("R5", "int_en cleared", int_en, 0);
      chk("R7", "irq after disable", irq, 0);
   endtask

   task automatic t_priority();
      issue(16'hF800, 16'h0000, 1'b1);
      rx_strobe = 1'b1;
      settle();
      chk("R6", "rx set wins over load", rx_flag, 1);
      issue(16'hF400, 16'h0033, 1'b1);
      tx_done = 1'b1;
      settle();
      chk("R6", "tx set wins over send", tx_flag, 1);
      chk("R3", "tx_valid with done", tx_valid, 1);
      settle();
   endtask

   task automatic t_ignored();
      logic [15:0] words [4] = '{16'hF000, 16'hF0C0, 16'h7800, 16'hF801};
      issue(16'hF080, 16'h0000, 1'b1);
      settle();
      for (int i = 0; i < 4; i++) begin
         issue(words[i], 16'h4321, 1'b1);
         chk("R8", "acc_we", acc_we, 0);
         chk("R8", "acc_out", acc_out, 16'h4321);
         chk("R8", "skip", skip_req, 0);
         settle();
         chk("R8", "rx_flag kept", rx_flag, 1);
         chk("R8", "tx_flag kept", tx_flag, 1);
         chk("R8", "int_en kept", int_en, 1);
         chk("R8", "tx_valid", tx_valid, 0);
      end
      issue(16'hF800, 16'h4321, 1'b0);
      chk("R8", "acc_we no exec", acc_we, 0);
      settle();
      chk("R8", "rx_flag no exec", rx_flag, 1);
      issue(16'hF040, 16'h0000, 1'b0);
      settle();
      chk("R8", "int_en no exec", int_en, 1);
   endtask

   initial begin
      t_reset();
      t_rx_and_skip();
      t_load();
      t_send();
      t_interrupts();
      t_priority();
      t_ignored();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      #200000;
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end
endmodule